// File: doc/BRIEF.md
# IO page table translation engine

This engine turns a device-side virtual address into a 36-bit physical address by looking it up in a single-level page table held in memory. A requester presents an address together with a write flag. The engine works out where the matching 4-byte entry lives, reads that entry through a memory read port with separate request and response handshakes, and then tests its valid and writable bits. It answers with either the physical address or a fault. When it faults, it also pulses a strobe that carries a status word and the page address to the register file, which then raises the interrupt.

The translation window is a power-of-two region at the top of the address space, from 16 MB up to 2 GB. A 3-bit size code selects it. Pages are 4 KB. A DMA transfer that spans several pages is issued as one request per page, and the requester drops the remaining pages at the first fault. Only one translation is in flight at a time, and no entries are cached.

Top module: `iox_xlate_top`

## Requirements
- R1: After reset, req_ready_o is 1 and rsp_valid_o, mem_req_valid_o and flt_strobe_o are 0.
- R2: The entry address on mem_req_addr_o is (cfg_base_i << 4) plus ((req_addr_i AND window mask) >> 12) × 4. The window mask keeps the low 24 + cfg_range_i bits, so code 0 selects 16 MB and code 7 selects 2 GB.
- R3: For a successful translation, rsp_pa_o is {entry[31:8], req_addr_i[11:0]} and rsp_fault_o is 0. The entry word is big-endian, with the byte at the lowest address in bits [31:24].
- R4: An entry with bit 1 (valid) clear gives rsp_fault_o = 1 and rsp_pa_o = 0 for both reads and writes.
- R5: A write whose entry has bit 2 (writable) clear faults. A read of a valid entry with bit 2 clear is translated normally.
- R6: On a fault, flt_strobe_o is high for exactly one cycle, in the first cycle of the response. At that time flt_status_o is 0xC0820000 for a write and 0xC0860000 for a read, and flt_addr_o is req_addr_i with bits [11:0] cleared.
- R7: req_ready_o is 1 only when the engine is idle. A request presented while it is busy is ignored and starts no memory fetch.
- R8: The response holds rsp_pa_o and rsp_fault_o stable until rsp_ready_i is taken. The memory request holds mem_req_addr_o stable until mem_req_ready_i is taken.
- R9: A fault leaves no state behind, so the next request, for example the next page of a transfer, is translated normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_base_i | input | 32 | Page table base register value |
| cfg_range_i | input | 3 | Window size code (16 MB << code) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Engine idle, request taken |
| req_addr_i | input | 32 | Device virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| mem_req_valid_o | output | 1 | Entry fetch request valid |
| mem_req_ready_i | input | 1 | Memory accepts fetch |
| mem_req_addr_o | output | 32 | Entry byte address |
| mem_rsp_valid_i | input | 1 | Entry word valid |
| mem_rsp_ready_o | output | 1 | Engine waiting for entry word |
| mem_rsp_data_i | input | 32 | Entry word, big-endian |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Consumer takes result |
| rsp_pa_o | output | 36 | Physical address, 0 on fault |
| rsp_fault_o | output | 1 | Translation faulted |
| flt_strobe_o | output | 1 | One-cycle fault report |
| flt_status_o | output | 32 | Fault status word |
| flt_addr_o | output | 32 | Page-aligned faulting address |

## Verification
The assertions assume a well-behaved memory port: mem_rsp_valid_i is raised only while mem_rsp_ready_o is high, and each fetch gets exactly one response word. They also assume the configuration inputs do not change while a request is being accepted. The bench models the memory as a slave that answers only after it has taken the fetch request, adding a wait cycle on both handshakes. It changes cfg_base_i and cfg_range_i only between translations. Requests presented while the engine is busy are driven on purpose, to show that they are ignored.

// File: rtl/iox_pkg.sv
package iox_pkg;
  localparam int VA_W         = 32;
  localparam int PAGE_SHIFT   = 12;
  localparam int PTE_W        = 32;
  localparam int PPN_LSB      = 8;
  localparam int PA_W         = PTE_W - PPN_LSB + PAGE_SHIFT;
  localparam int RANGE_W      = 3;
  localparam int MIN_WIN_LOG2 = 24;
  localparam int PTE_WR_BIT   = 2;
  localparam int PTE_V_BIT    = 1;
  localparam int ST_W         = 32;
  localparam logic [ST_W-1:0] FLT_BASE = 32'hC082_0000;
  localparam logic [ST_W-1:0] FLT_RD   = 32'h0004_0000;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_RESP} iox_state_e;
endpackage

// File: rtl/iox_entry_addr.sv
module iox_entry_addr
  import iox_pkg::*;
#(
  parameter int AW = VA_W,
  parameter int RW = RANGE_W
) (
  input  logic [AW-1:0] va_i,
  input  logic [AW-1:0] base_i,
  input  logic [RW-1:0] range_i,
  output logic [AW-1:0] ea_o
);
  logic [AW-1:0] win_mask;
  logic [AW-1:0] offset;
  logic [PAGE_SHIFT-1:0] unused_off;

  for (genvar i = 0; i < AW; i++) begin : g_mask
    assign win_mask[i] = (i < (MIN_WIN_LOG2 + int'(range_i)));
  end

  assign offset     = va_i & win_mask;
  assign unused_off = offset[PAGE_SHIFT-1:0];
  // one 4-byte entry per page
  assign ea_o = (base_i << 4) + AW'({offset[AW-1:PAGE_SHIFT], 2'b00});
endmodule

// File: rtl/iox_entry_check.sv
module iox_entry_check
  import iox_pkg::*;
#(
  parameter int AW  = VA_W,
  parameter int PW  = PTE_W,
  parameter int PAW = PA_W
) (
  input  logic [AW-1:0]   va_i,
  input  logic            wr_i,
  input  logic [PW-1:0]   pte_i,
  output logic [PAW-1:0]  pa_o,
  output logic            fault_o,
  output logic [ST_W-1:0] status_o,
  output logic [AW-1:0]   fault_addr_o
);
  logic unused_pte;
  assign unused_pte = ^{pte_i[PPN_LSB-1:PTE_WR_BIT+1], pte_i[PTE_V_BIT-1:0]};

  assign fault_o      = !pte_i[PTE_V_BIT] || (wr_i && !pte_i[PTE_WR_BIT]);
  assign pa_o         = fault_o ? '0 : {pte_i[PW-1:PPN_LSB], va_i[PAGE_SHIFT-1:0]};
  assign status_o     = FLT_BASE | (wr_i ? '0 : FLT_RD);
  assign fault_addr_o = {va_i[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
endmodule

// File: rtl/iox_xlate_top.sv
module iox_xlate_top
  import iox_pkg::*;
#(
  parameter int AW  = VA_W,
  parameter int RW  = RANGE_W,
  parameter int PW  = PTE_W,
  parameter int PAW = PA_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   cfg_base_i,
  input  logic [RW-1:0]   cfg_range_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [AW-1:0]   req_addr_i,
  input  logic            req_write_i,
  output logic            mem_req_valid_o,
  input  logic            mem_req_ready_i,
  output logic [AW-1:0]   mem_req_addr_o,
  input  logic            mem_rsp_valid_i,
  output logic            mem_rsp_ready_o,
  input  logic [PW-1:0]   mem_rsp_data_i,
  output logic            rsp_valid_o,
  input  logic            rsp_ready_i,
  output logic [PAW-1:0]  rsp_pa_o,
  output logic            rsp_fault_o,
  output logic            flt_strobe_o,
  output logic [ST_W-1:0] flt_status_o,
  output logic [AW-1:0]   flt_addr_o
);
  iox_state_e state_q;
  logic [AW-1:0]   va_q, ea_q, faddr_q;
  logic            wr_q, fault_q, strobe_q;
  logic [PAW-1:0]  pa_q;
  logic [ST_W-1:0] status_q;

  logic [AW-1:0]   ea_d, faddr_d;
  logic [PAW-1:0]  pa_d;
  logic            fault_d;
  logic [ST_W-1:0] status_d;

  iox_entry_addr #(.AW(AW), .RW(RW)) u_ea (
    .va_i   (req_addr_i),
    .base_i (cfg_base_i),
    .range_i(cfg_range_i),
    .ea_o   (ea_d)
  );

  iox_entry_check #(.AW(AW), .PW(PW), .PAW(PAW)) u_chk (
    .va_i        (va_q),
    .wr_i        (wr_q),
    .pte_i       (mem_rsp_data_i),
    .pa_o        (pa_d),
    .fault_o     (fault_d),
    .status_o    (status_d),
    .fault_addr_o(faddr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      va_q     <= '0;
      wr_q     <= 1'b0;
      ea_q     <= '0;
      pa_q     <= '0;
      fault_q  <= 1'b0;
      strobe_q <= 1'b0;
      status_q <= '0;
      faddr_q  <= '0;
    end else begin
      strobe_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (req_valid_i) begin
          va_q    <= req_addr_i;
          wr_q    <= req_write_i;
          ea_q    <= ea_d;
          state_q <= S_FETCH;
        end
        S_FETCH: if (mem_req_ready_i) state_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid_i) begin
          pa_q     <= pa_d;
          fault_q  <= fault_d;
          strobe_q <= fault_d;
          status_q <= status_d;
          faddr_q  <= faddr_d;
          state_q  <= S_RESP;
        end
        S_RESP: if (rsp_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == S_IDLE);
  assign mem_req_valid_o = (state_q == S_FETCH);
  assign mem_req_addr_o  = ea_q;
  assign mem_rsp_ready_o = (state_q == S_WAIT);
  assign rsp_valid_o     = (state_q == S_RESP);
  assign rsp_pa_o        = pa_q;
  assign rsp_fault_o     = fault_q;
  assign flt_strobe_o    = strobe_q;
  assign flt_status_o    = status_q;
  assign flt_addr_o      = faddr_q;

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || mem_req_valid_o || mem_rsp_ready_o) |-> !req_ready_o); // R7
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_pa_o) && $stable(rsp_fault_o))); // R8
  AST_MEMREQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o))); // R8
  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_strobe_o |=> !flt_strobe_o); // R6
  AST_STROBE_AT_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_strobe_o |-> ($rose(rsp_valid_o) && rsp_fault_o)); // R6
  AST_FAULT_PA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_pa_o == '0)); // R4
  AST_FETCH_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> mem_req_valid_o); // R7
endmodule

// File: tb/sim_iox_xlate_top.sv
`timescale 1ns/1ps
module sim_iox_xlate_top;
  localparam time CLK_P = 20ns;

  typedef struct packed {
    logic [31:0] base;
    logic [2:0]  rng;
    logic [31:0] va;
    logic        wr;
    logic [31:0] pte;
    logic [31:0] ea;
    logic [35:0] pa;
    logic        flt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0400, 3'd0, 32'hFF01_2345, 1'b0, 32'h00AB_CD02, 32'h0000_4048, 36'h00ABCD345, 1'b0},
    '{32'h0000_0400, 3'd7, 32'h8000_3ABC, 1'b1, 32'h1234_5606, 32'h0000_400C, 36'h123456ABC, 1'b0},
    '{32'h0001_0000, 3'd1, 32'hFE12_3FFF, 1'b1, 32'h1234_5602, 32'h0010_048C, 36'h0,         1'b1},
    '{32'h0000_1000, 3'd4, 32'hF000_0000, 1'b0, 32'h1234_5604, 32'h0001_0000, 36'h0,         1'b1},
    '{32'h0000_0000, 3'd6, 32'hC000_0FFF, 1'b0, 32'hFFFF_FF82, 32'h0000_0000, 36'hFFFFFFFFF, 1'b0},
    '{32'h0000_0400, 3'd3, 32'h1234_5678, 1'b1, 32'h0000_0005, 32'h0000_CD14, 36'h0,         1'b1},
    '{32'h0000_0400, 3'd2, 32'hFFFF_F010, 1'b0, 32'h0000_010A, 32'h0001_3FFC, 36'h000001010, 1'b0},
    '{32'h0000_0000, 3'd5, 32'hE000_1000, 1'b1, 32'h0000_0106, 32'h0000_0004, 36'h000001000, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [2:0]  cfg_range = '0;
  logic req_valid = 1'b0, req_write = 1'b0, mem_req_ready = 1'b0;
  logic mem_rsp_valid = 1'b0, rsp_ready = 1'b0;
  logic [31:0] req_addr = '0, mem_rsp_data = '0;
  logic req_ready, mem_req_valid, mem_rsp_ready, rsp_valid, rsp_fault, flt_strobe;
  logic [31:0] mem_req_addr, flt_status, flt_addr;
  logic [35:0] rsp_pa;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  iox_xlate_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_base_i(cfg_base), .cfg_range_i(cfg_range),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_write_i(req_write), .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid), .mem_rsp_ready_o(mem_rsp_ready),
    .mem_rsp_data_i(mem_rsp_data), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault), .flt_strobe_o(flt_strobe),
    .flt_status_o(flt_status), .flt_addr_o(flt_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one translation; poke drives a request while busy (R7)
  task automatic xlate(input vec_t v, input int lat, input int hold, input bit poke, input string tag);
    logic [31:0] exp_st;
    @(negedge clk);
    cfg_base = v.base; cfg_range = v.rng;
    req_addr = v.va; req_write = v.wr; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R7", {tag, " idle ready"}, 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < lat; i++) begin
      if (poke && i == 0) begin
        req_valid = 1'b1; req_addr = ~v.va; req_write = ~v.wr;
      end
      chk(mem_req_valid && mem_req_addr == v.ea, "R8", {tag, " fetch hold"}, 64'(mem_req_addr), 64'(v.ea));
      if (poke) chk(req_ready == 1'b0, "R7", {tag, " busy ready"}, 64'(req_ready), 64'd0);
      @(negedge clk);
      req_valid = 1'b0;
    end
    chk(mem_req_valid && mem_req_addr == v.ea, "R2", {tag, " entry addr"}, 64'(mem_req_addr), 64'(v.ea));
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(mem_rsp_ready && !mem_req_valid && !rsp_valid, "R8", {tag, " waiting"}, 64'(mem_rsp_ready), 64'd1);
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = v.pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    chk(rsp_valid && rsp_fault == v.flt, v.flt ? "R4/R5" : "R5", {tag, " fault flag"}, 64'(rsp_fault), 64'(v.flt));
    chk(rsp_pa == v.pa, v.flt ? "R4" : "R3", {tag, " pa"}, 64'(rsp_pa), 64'(v.pa));
    chk(flt_strobe == v.flt, "R6", {tag, " strobe"}, 64'(flt_strobe), 64'(v.flt));
    if (v.flt) begin
      exp_st = v.wr ? 32'hC082_0000 : 32'hC086_0000;
      chk(flt_status == exp_st, "R6", {tag, " status"}, 64'(flt_status), 64'(exp_st));
      chk(flt_addr == {v.va[31:12], 12'h000}, "R6", {tag, " fault addr"},
          64'(flt_addr), 64'({v.va[31:12], 12'h000}));
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_pa == v.pa && rsp_fault == v.flt, "R8", {tag, " rsp hold"}, 64'(rsp_pa), 64'(v.pa));
      chk(!flt_strobe, "R6", {tag, " strobe single"}, 64'(flt_strobe), 64'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R8", {tag, " released"}, 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid && !flt_strobe, "R1", "reset outputs",
        64'({req_ready, rsp_valid, mem_req_valid, flt_strobe}), 64'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid && !flt_strobe, "R1", "after reset",
        64'({req_ready, rsp_valid, mem_req_valid, flt_strobe}), 64'b1000);

    // vector walk: R2 windows/base, R3 pa, R4 invalid, R5 write perm, R6 fault report
    for (int k = 0; k < NV; k++) begin
      xlate(VECS[k], k % 3, k % 4, 1'b0, $sformatf("vec%0d", k));
    end

    // R7: request presented during busy is ignored
    xlate(VECS[0], 2, 1, 1'b1, "busy");
    repeat (3) begin
      @(negedge clk);
      chk(!mem_req_valid && req_ready, "R7", "no stray fetch", 64'(mem_req_valid), 64'd0);
    end

    // R9: pages of one transfer, fault then fresh request translates normally
    xlate(VECS[6], 0, 0, 1'b0, "R9 page0");
    xlate(VECS[5], 1, 0, 1'b0, "R9 page1 fault");
    xlate(VECS[7], 0, 2, 1'b0, "R9 after fault");

    // R1: reset mid-transaction returns to idle
    @(negedge clk);
    req_addr = VECS[1].va; req_write = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !rsp_valid, "R1", "reset mid-fetch",
        64'({req_ready, mem_req_valid, rsp_valid}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule